// File: doc/BRIEF.md
# Window Colour Lookup Table with Global Second Stage

This block holds a three-channel, 256-entry table that sits in a display window's pixel path. With true-colour or converted YUV content it works as a gamma curve. Each 8-bit channel value selects an entry in that channel's own column. In palette mode the pixel carries an index on its red lane, and that one index reads all three columns, so the table acts as the colour palette. By default each result then passes through a second, global table. An override flag sends the first-stage result straight to the output and skips the global stage.

Software loads the window table through a configuration port. A request gives a first entry, an entry count and new flag values. The data words then arrive one per accepted beat, each holding three 16-bit channel values. A count of zero only changes the flags. A range that runs past the last entry is cut off there, and an error flag reports it. Table writes stall while a line of pixels is in flight, so a line never mixes old and new entries. The global table has its own write port that loads one entry per cycle.

Top module: `pix_lut`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `cfg_busy`, `cfg_err` and `cfg_wready` are 0 and both flags are 0.
- R2: With flags bit 0 (override) and bit 1 (palette) clear, each output channel equals G[c][W[c][x]]. Here x is that channel's input value, W is the window table and G is the global table. The result appears 2 cycles after the input. `out_valid` and `out_side` are delayed by the same 2 cycles.
- R3: With flags bit 0 set, each output channel equals W[c][x]. The latency stays at 2 cycles.
- R4: With flags bit 1 set, the red input is the index for all three channels. The green and blue inputs have no effect. The global stage still applies unless bit 0 is set.
- R5: Each host word is 16 bits. The table keeps its upper byte and ignores its lower byte. In `cfg_wdata`, red is bits 47:32, green is bits 31:16 and blue is bits 15:0.
- R6: A request with a nonzero count writes consecutive entries from the start index, one per accepted beat. `cfg_busy` drops after the last beat. Entries outside the range keep their values.
- R7: A request with a count of 0 updates the flags in the next cycle. `cfg_busy` stays low and the table is not changed.
- R8: When start + count exceeds 256, entries start..255 are written. The remaining beats are still accepted but discarded, with no wrap to entry 0, and `cfg_err` is 1 after the request. The next request sets `cfg_err` from its own range.
- R9: While `line_active` is high, `cfg_wready` is low, no beat is taken and the table keeps its contents.
- R10: A cycle with `glb_we` high writes `glb_rgb` into global entry `glb_addr`, with red in bits 23:16, green in 15:8 and blue in 7:0.
- R11: A request that arrives while `cfg_busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_req | input | 1 | Start an update (taken when not busy) |
| cfg_start | input | 8 | First entry to write |
| cfg_len | input | 9 | Number of entries (0..256) |
| cfg_flags | input | 2 | Bit 0 global override, bit 1 palette mode |
| cfg_wvalid | input | 1 | Data beat present |
| cfg_wdata | input | 48 | Red, green, blue 16-bit host values |
| cfg_wready | output | 1 | Beat accepted this cycle |
| cfg_busy | output | 1 | Range update in progress |
| cfg_err | output | 1 | Last request ran past entry 255 |
| line_active | input | 1 | Pixels in flight; holds off table writes |
| glb_we | input | 1 | Global table write strobe |
| glb_addr | input | 8 | Global entry index |
| glb_rgb | input | 24 | Global entry value |
| pix_valid | input | 1 | Input pixel valid |
| pix_r | input | 8 | Red value or palette index |
| pix_g | input | 8 | Green value |
| pix_b | input | 8 | Blue value |
| pix_side | input | 4 | Sideband carried with the pixel |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 8 | Red result |
| out_g | output | 8 | Green result |
| out_b | output | 8 | Blue result |
| out_side | output | 4 | Delayed sideband |

## Verification
A pixel result is due on the second rising edge after it is driven, in both the bypass and the two-table paths. The bench drives on falling edges and holds a two-deep queue of expected results. Each falling edge compares the outputs with the entry queued two edges earlier, including `out_valid` and `out_side`. Configuration outputs depend on the edge that takes the request, so `cfg_busy` and `cfg_err` are read one falling edge after the request. `cfg_wready` is read just before the edge that would consume a beat.

// File: rtl/pix_lut_pkg.sv
// Package: shared constants and types for the window colour lookup table.
// Assumes three colour channels indexed 0 = blue, 1 = green, 2 = red.
package pix_lut_pkg;
    localparam int CH_N    = 3;
    localparam int FLAG_W  = 2;
    localparam int FLG_OVR = 0;   // skip the global stage
    localparam int FLG_PAL = 1;   // red lane is a palette index

    typedef enum logic { LD_IDLE = 1'b0, LD_FILL = 1'b1 } ld_state_e;
endpackage

// File: rtl/pix_lut_ram.sv
// Module: single-port-write, single-port-read table with registered read.
// Assumes a read and a write to the same entry in one cycle return the old value.
module pix_lut_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Write one entry and register one read per cycle.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/pix_lut_loader.sv
// Module: range loader for the window table. Takes a request (start, count,
// flags), then takes one data beat per cycle while no line is active. It keeps
// the upper byte of each 16-bit channel value and drops beats that fall past
// the last entry.
// Assumes the host supplies exactly `len` beats after a nonzero request.
module pix_lut_loader
    import pix_lut_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter int HW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [AW-1:0]      start,
    input  logic [AW:0]        len,
    input  logic [FLAG_W-1:0]  flags_in,
    input  logic               wvalid,
    input  logic [CH_N*HW-1:0] wdata,
    input  logic               line_active,
    output logic               wready,
    output logic               busy,
    output logic               err,
    output logic [FLAG_W-1:0]  flags,
    output logic               wr_en,
    output logic [AW-1:0]      wr_addr,
    output logic [CH_N*DW-1:0] wr_data
);
    localparam int DEPTH = 1 << AW;
    localparam int LW    = AW + 1;
    localparam int SW    = AW + 2;

    ld_state_e     st;
    logic [LW-1:0] idx;
    logic [LW-1:0] left;
    logic [SW-1:0] span_end;
    logic          beat;

    assign span_end = SW'(start) + SW'(len);
    assign busy     = (st == LD_FILL);
    assign wready   = busy & ~line_active;
    assign beat     = wready & wvalid;
    assign wr_en    = beat & ~idx[AW];
    assign wr_addr  = idx[AW-1:0];

    // Keep the upper byte of each host channel word.
    for (genvar c = 0; c < CH_N; c++) begin : g_narrow
        assign wr_data[c*DW +: DW] = wdata[c*HW + (HW - DW) +: DW];
    end

    // Accept requests and step through the range one beat at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= LD_IDLE;
            idx   <= '0;
            left  <= '0;
            err   <= 1'b0;
            flags <= '0;
        end else begin
            case (st)
                LD_IDLE: begin
                    if (req) begin
                        flags <= flags_in;
                        err   <= (span_end > SW'(DEPTH));
                        if (len != '0) begin
                            st   <= LD_FILL;
                            idx  <= LW'(start);
                            left <= len;
                        end
                    end
                end
                LD_FILL: begin
                    if (beat) begin
                        idx  <= idx + LW'(1);
                        left <= left - LW'(1);
                        if (left == LW'(1)) begin
                            st <= LD_IDLE;
                        end
                    end
                end
                default: st <= LD_IDLE;
            endcase
        end
    end

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && $past(wr_en) |-> wr_addr == $past(wr_addr) + AW'(1));
    // R7
    len_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req && !busy && len == '0 |=> !busy && !wr_en);
    // R8
    trunc_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req && !busy |=> err == $past(span_end > SW'(DEPTH)));
    // R9
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && line_active |=> busy && $stable(idx));
    // R11
    busy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && req |=> $stable(flags));
endmodule

// File: rtl/pix_lut.sv
// Module: top of the window lookup table. Stage 1 reads the per-window table,
// addressed either per channel or by the red lane in palette mode. Stage 2
// reads the global table, or a matching bypass register when the override
// flag is set. The latency is always 2 cycles, and valid and sideband follow
// the data.
// Assumes the host raises line_active for as long as pixels of a line flow.
module pix_lut
    import pix_lut_pkg::*;
#(
    parameter int AW     = 8,
    parameter int DW     = 8,
    parameter int HW     = 16,
    parameter int SIDE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_req,
    input  logic [AW-1:0]      cfg_start,
    input  logic [AW:0]        cfg_len,
    input  logic [FLAG_W-1:0]  cfg_flags,
    input  logic               cfg_wvalid,
    input  logic [CH_N*HW-1:0] cfg_wdata,
    output logic               cfg_wready,
    output logic               cfg_busy,
    output logic               cfg_err,
    input  logic               line_active,
    input  logic               glb_we,
    input  logic [AW-1:0]      glb_addr,
    input  logic [CH_N*DW-1:0] glb_rgb,
    input  logic               pix_valid,
    input  logic [DW-1:0]      pix_r,
    input  logic [DW-1:0]      pix_g,
    input  logic [DW-1:0]      pix_b,
    input  logic [SIDE_W-1:0]  pix_side,
    output logic               out_valid,
    output logic [DW-1:0]      out_r,
    output logic [DW-1:0]      out_g,
    output logic [DW-1:0]      out_b,
    output logic [SIDE_W-1:0]  out_side
);
    logic [FLAG_W-1:0]  cur_flags;
    logic               ld_we;
    logic [AW-1:0]      ld_addr;
    logic [CH_N*DW-1:0] ld_data;

    logic [DW-1:0] lane_in  [CH_N];
    logic [AW-1:0] win_ra   [CH_N];
    logic [DW-1:0] win_q    [CH_N];
    logic [DW-1:0] glb_q    [CH_N];
    logic [DW-1:0] byp_q    [CH_N];
    logic [DW-1:0] out_lane [CH_N];

    logic              s1_valid, s2_valid;
    logic              s1_ovr,   s2_ovr;
    logic [SIDE_W-1:0] s1_side,  s2_side;

    pix_lut_loader #(.AW(AW), .DW(DW), .HW(HW)) u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (cfg_req),
        .start      (cfg_start),
        .len        (cfg_len),
        .flags_in   (cfg_flags),
        .wvalid     (cfg_wvalid),
        .wdata      (cfg_wdata),
        .line_active(line_active),
        .wready     (cfg_wready),
        .busy       (cfg_busy),
        .err        (cfg_err),
        .flags      (cur_flags),
        .wr_en      (ld_we),
        .wr_addr    (ld_addr),
        .wr_data    (ld_data)
    );

    assign lane_in[0] = pix_b;
    assign lane_in[1] = pix_g;
    assign lane_in[2] = pix_r;

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        // Palette mode indexes every channel with the red lane.
        assign win_ra[c] = cur_flags[FLG_PAL] ? AW'(pix_r) : AW'(lane_in[c]);

        pix_lut_ram #(.AW(AW), .DW(DW)) u_win (
            .clk  (clk),
            .we   (ld_we),
            .waddr(ld_addr),
            .wdata(ld_data[c*DW +: DW]),
            .raddr(win_ra[c]),
            .rdata(win_q[c])
        );

        pix_lut_ram #(.AW(AW), .DW(DW)) u_glb (
            .clk  (clk),
            .we   (glb_we),
            .waddr(glb_addr),
            .wdata(glb_rgb[c*DW +: DW]),
            .raddr(AW'(win_q[c])),
            .rdata(glb_q[c])
        );

        // Bypass register matching the global stage latency.
        always_ff @(posedge clk) begin
            byp_q[c] <= win_q[c];
        end

        assign out_lane[c] = s2_ovr ? byp_q[c] : glb_q[c];
    end

    // Carry valid, sideband and override alongside the two table stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s2_valid <= 1'b0;
            s1_ovr   <= 1'b0;
            s2_ovr   <= 1'b0;
            s1_side  <= '0;
            s2_side  <= '0;
        end else begin
            s1_valid <= pix_valid;
            s1_ovr   <= cur_flags[FLG_OVR];
            s1_side  <= pix_side;
            s2_valid <= s1_valid;
            s2_ovr   <= s1_ovr;
            s2_side  <= s1_side;
        end
    end

    assign out_valid = s2_valid;
    assign out_side  = s2_side;
    assign out_b     = out_lane[0];
    assign out_g     = out_lane[1];
    assign out_r     = out_lane[2];

    // R2
    lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(pix_valid, 2));
    // R2
    lat_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_side == $past(pix_side, 2));
    // R9
    no_write_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_active |-> !ld_we);
endmodule

// File: tb/pix_lut_bench.sv
`timescale 1ns/1ps
module pix_lut_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_req;
    logic [7:0]  cfg_start;
    logic [8:0]  cfg_len;
    logic [1:0]  cfg_flags;
    logic        cfg_wvalid;
    logic [47:0] cfg_wdata;
    logic        cfg_wready, cfg_busy, cfg_err;
    logic        line_active;
    logic        glb_we;
    logic [7:0]  glb_addr;
    logic [23:0] glb_rgb;
    logic        pix_valid;
    logic [7:0]  pix_r, pix_g, pix_b;
    logic [3:0]  pix_side;
    logic        out_valid;
    logic [7:0]  out_r, out_g, out_b;
    logic [3:0]  out_side;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    logic [7:0] wm [3][256];
    logic [7:0] gm [3][256];
    logic [1:0] mflags;

    logic        q_v [2];
    logic [23:0] q_rgb [2];
    logic [3:0]  q_s [2];

    always #2 clk = ~clk;

    pix_lut u_pix_lut (
        .clk(clk), .rst_n(rst_n),
        .cfg_req(cfg_req), .cfg_start(cfg_start), .cfg_len(cfg_len),
        .cfg_flags(cfg_flags), .cfg_wvalid(cfg_wvalid), .cfg_wdata(cfg_wdata),
        .cfg_wready(cfg_wready), .cfg_busy(cfg_busy), .cfg_err(cfg_err),
        .line_active(line_active),
        .glb_we(glb_we), .glb_addr(glb_addr), .glb_rgb(glb_rgb),
        .pix_valid(pix_valid), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .pix_side(pix_side),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b),
        .out_side(out_side)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            finish_run();
        end
    end

    // Expected channel c (0 blue, 1 green, 2 red) from the bench tables.
    function automatic logic [7:0] exp_ch(int c, logic [7:0] r, logic [7:0] g,
                                          logic [7:0] b, logic [1:0] f);
        logic [7:0] ix;
        logic [7:0] w;
        ix = f[1] ? r : (c == 2 ? r : (c == 1 ? g : b));
        w  = wm[c][ix];
        return f[0] ? w : gm[c][w];
    endfunction

    // Load every global entry with random values (R10).
    task automatic load_global();
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            glb_we   = 1'b1;
            glb_addr = 8'(i);
            glb_rgb  = 24'($urandom);
            gm[2][i] = glb_rgb[23:16];
            gm[1][i] = glb_rgb[15:8];
            gm[0][i] = glb_rgb[7:0];
        end
        @(negedge clk);
        glb_we = 1'b0;
    endtask

    // Range update with optional hold-off cycles before the beats.
    task automatic load(input int start, input int len, input logic [1:0] f,
                        input int hold);
        bit acc;
        bit exp_err;
        int idx;
        @(negedge clk);
        cfg_req   = 1'b1;
        cfg_start = 8'(start);
        cfg_len   = 9'(len);
        cfg_flags = f;
        exp_err   = (start + len) > 256;
        @(negedge clk);
        cfg_req = 1'b0;
        mflags  = f;
        chk(cfg_err == exp_err, "R8 err after request", 32'(cfg_err), 32'(exp_err));
        if (len == 0) begin
            chk(cfg_busy == 1'b0, "R7 busy stays low", 32'(cfg_busy), 0);
            return;
        end
        chk(cfg_busy == 1'b1, "R6 busy after request", 32'(cfg_busy), 1);
        if (hold > 0) begin
            line_active = 1'b1;
            cfg_wvalid  = 1'b1;
            cfg_wdata   = 48'hFFFF_FFFF_FFFF;
            for (int h = 0; h < hold; h++) begin
                #1;
                chk(cfg_wready == 1'b0, "R9 wready held low", 32'(cfg_wready), 0);
                @(negedge clk);
            end
            line_active = 1'b0;
        end
        // A second request during the burst must be ignored (R11).
        cfg_req   = 1'b1;
        cfg_flags = ~f;
        cfg_len   = 9'd0;
        idx = start;
        for (int k = 0; k < len; k++) begin
            cfg_wvalid = 1'b1;
            cfg_wdata  = {16'($urandom), 16'($urandom), 16'($urandom)};
            do begin
                #1;
                acc = cfg_wready;
                @(negedge clk);
                cfg_req = 1'b0;
            end while (!acc);
            if (idx < 256) begin
                wm[2][idx] = cfg_wdata[47:40];
                wm[1][idx] = cfg_wdata[31:24];
                wm[0][idx] = cfg_wdata[15:8];
            end
            idx++;
        end
        cfg_wvalid = 1'b0;
        chk(cfg_busy == 1'b0, "R6 busy drops after last beat", 32'(cfg_busy), 0);
        chk(cfg_err == exp_err, "R8/R11 err held through burst", 32'(cfg_err), 32'(exp_err));
    endtask

    // Stream n pixel slots and compare each output two edges after its input.
    task automatic stream(input int n, input string req);
        logic [7:0] r, g, b;
        q_v[0] = 1'b0;
        q_v[1] = 1'b0;
        line_active = 1'b1;
        for (int i = 0; i < n + 2; i++) begin
            @(negedge clk);
            chk(out_valid == q_v[1], req, 32'(out_valid), 32'(q_v[1]));
            if (q_v[1]) begin
                chk({out_r, out_g, out_b} == q_rgb[1], req,
                    32'({out_r, out_g, out_b}), 32'(q_rgb[1]));
                chk(out_side == q_s[1], req, 32'(out_side), 32'(q_s[1]));
            end
            q_v[1] = q_v[0]; q_rgb[1] = q_rgb[0]; q_s[1] = q_s[0];
            if (i < n) begin
                pix_valid = ($urandom % 4) != 0;
                r = 8'($urandom); g = 8'($urandom); b = 8'($urandom);
                pix_r = r; pix_g = g; pix_b = b;
                pix_side = 4'($urandom);
            end else begin
                pix_valid = 1'b0;
            end
            q_v[0]   = pix_valid;
            q_rgb[0] = {exp_ch(2, pix_r, pix_g, pix_b, mflags),
                        exp_ch(1, pix_r, pix_g, pix_b, mflags),
                        exp_ch(0, pix_r, pix_g, pix_b, mflags)};
            q_s[0]   = pix_side;
        end
        line_active = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240917));
        rst_n = 1'b0; cfg_req = 1'b0; cfg_start = '0; cfg_len = '0;
        cfg_flags = '0; cfg_wvalid = 1'b0; cfg_wdata = '0; line_active = 1'b0;
        glb_we = 1'b0; glb_addr = '0; glb_rgb = '0;
        pix_valid = 1'b0; pix_r = '0; pix_g = '0; pix_b = '0; pix_side = '0;
        mflags = 2'b00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 0);
        chk(cfg_busy == 1'b0, "R1 busy", 32'(cfg_busy), 0);
        chk(cfg_err == 1'b0, "R1 err", 32'(cfg_err), 0);
        chk(cfg_wready == 1'b0, "R1 wready", 32'(cfg_wready), 0);

        load_global();
        load(0, 256, 2'b00, 0);
        stream(400, "R2/R5/R10 gamma through both tables");
        load(0, 0, 2'b01, 0);
        stream(300, "R3/R7 override after flags-only update");
        load(16, 20, 2'b01, 5);
        stream(400, "R3/R6/R9 partial range after hold-off");
        load(250, 10, 2'b00, 0);
        stream(600, "R2/R8 truncated range without wrap");
        load(100, 5, 2'b10, 0);
        stream(400, "R4/R8 palette through global table");
        load(0, 0, 2'b11, 0);
        stream(400, "R4/R3 palette with override");
        finish_run();
    end
endmodule